// File: doc/BRIEF.md
# Shared High-Byte Register Port

This block connects an 8-bit bus to a bank of wide registers, 10 bits each by default, such as a counter and its compare values. Each wide register takes up one bus address, which carries its low byte. The bits above the low byte are not mapped per register. They all pass through one small staging register that every wide register shares, and that staging register has its own bus address.

Software reads a wide value by reading the low byte first. That read also copies the register's upper bits into the staging register, so a following read of the staging address returns them. Software writes a wide value by loading the staging register first and then writing the low byte. The write stores the low byte and the staged upper bits in the same cycle. If the staging register holds zero, every wide register behaves as a plain 8-bit register. The register contents are brought out in parallel so the logic that uses them can read them directly.

Top module: `split_reg_access`

## Requirements
- R1: Synchronous active-high reset clears every wide register, the staging register and `rd_data` to zero.
- R2: A write to address i, where i is below NUM_REGS, updates register i on the next clock edge to {staging register, `wr_data`}. The other wide registers do not change. Register i appears on `reg_q[i*REG_W +: REG_W]`.
- R3: A write to the staging address, HI_ADDR (default 8), loads `wr_data[HI_W-1:0]` into the staging register and ignores the higher data bits. No wide register changes.
- R4: A read of the staging address sets `rd_data` to the staging value, zero-extended, one cycle after the strobe.
- R5: A read of address i, where i is below NUM_REGS, sets `rd_data` to the low byte of register i one cycle later. On the same edge it copies the upper HI_W bits of register i into the staging register.
- R6: A low-byte write made while the staging register is zero leaves the upper bits of that register at zero, so the register works as an 8-bit register.
- R7: An access to any other address changes no register and leaves the staging register unchanged. A read of such an address returns zero.
- R8: `rd_data` holds its value in every cycle in which `rd_en` is low.
- R9: A low-byte write does not change the staging register, so several low-byte writes in a row all receive the same upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Bus address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| reg_q | output | NUM_REGS*REG_W | Parallel contents of all wide registers, register i at bits i*REG_W |

## Verification
The assertions assume that the bus master never raises `rd_en` and `wr_en` in the same cycle. The properties that depend on this exclude that case in their antecedents. The bench drives a single strobe for one cycle on each falling edge and always drops it before starting the next access. As a result, every staging-register update comes from exactly one bus access, either a staging-address write or a low-byte read.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  // Class of bus access, derived from the address alone
  typedef enum logic [1:0] {
    ACC_LOW  = 2'd0,  // low byte of a wide register
    ACC_HIGH = 2'd1,  // shared staging register
    ACC_VOID = 2'd2   // unmapped
  } acc_kind_e;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h8
) (
  input  logic [ADDR_W-1:0]   addr,
  output acc_kind_e           kind,
  output logic [NUM_REGS-1:0] sel
);
  always_comb begin
    if (32'(addr) < NUM_REGS)  kind = ACC_LOW;
    else if (addr == HI_ADDR)  kind = ACC_HIGH;
    else                       kind = ACC_VOID;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (32'(addr) == i);
  end
endmodule

// File: rtl/hbr_hibuf.sv
module hbr_hibuf #(
  parameter int unsigned HI_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_bus,
  input  logic [HI_W-1:0] bus_val,
  input  logic            load_cap,
  input  logic [HI_W-1:0] cap_val,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst)           hi_q <= '0;
    else if (load_bus) hi_q <= bus_val;
    else if (load_cap) hi_q <= cap_val;
  end
endmodule

// File: rtl/hbr_regbank.sv
module hbr_regbank #(
  parameter int unsigned NUM_REGS = 5,
  parameter int unsigned REG_W    = 10,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REGS-1:0]       wr_sel,
  input  logic [DATA_W-1:0]         lo_in,
  input  logic [REG_W-DATA_W-1:0]   hi_in,
  output logic [NUM_REGS*REG_W-1:0] bank_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)            r <= '0;
      else if (wr_sel[i]) r <= {hi_in, lo_in};
    end
    assign bank_q[i*REG_W +: REG_W] = r;
  end
endmodule

// File: rtl/split_reg_access.sv
module split_reg_access
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_W    = 10,
  parameter int unsigned NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_REGS*REG_W-1:0] reg_q
);
  localparam int unsigned HI_W = REG_W - DATA_W;

  acc_kind_e           kind;
  logic [NUM_REGS-1:0] sel;
  logic [HI_W-1:0]     hi_q;
  logic [DATA_W-1:0]   mux_lo;
  logic [HI_W-1:0]     mux_hi;
  logic                wr_low, wr_high, rd_low;

  hbr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .HI_ADDR(HI_ADDR)) u_dec (
    .addr(addr), .kind(kind), .sel(sel)
  );

  assign wr_low  = wr_en && (kind == ACC_LOW);
  assign wr_high = wr_en && (kind == ACC_HIGH);
  assign rd_low  = rd_en && (kind == ACC_LOW);

  // Selected register split into bus byte and upper part
  always_comb begin
    mux_lo = '0;
    mux_hi = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) begin
        mux_lo = reg_q[i*REG_W +: DATA_W];
        mux_hi = reg_q[i*REG_W + DATA_W +: HI_W];
      end
    end
  end

  hbr_hibuf #(.HI_W(HI_W)) u_hibuf (
    .clk(clk), .rst(rst),
    .load_bus(wr_high), .bus_val(wr_data[HI_W-1:0]),
    .load_cap(rd_low),  .cap_val(mux_hi),
    .hi_q(hi_q)
  );

  hbr_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_sel(sel & {NUM_REGS{wr_low}}),
    .lo_in(wr_data), .hi_in(hi_q),
    .bank_q(reg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (kind)
        ACC_LOW:  rd_data <= mux_lo;
        ACC_HIGH: rd_data <= {{(DATA_W-HI_W){1'b0}}, hi_q};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hbr_access_chk.sv
module hbr_access_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_W    = 10,
  parameter int unsigned NUM_REGS = 5,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wr_data,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_REGS*REG_W-1:0] reg_q,
  input logic [REG_W-DATA_W-1:0]   hi_q
);
  localparam int unsigned HI_W = REG_W - DATA_W;

  function automatic logic [REG_W-1:0] pick(input logic [NUM_REGS*REG_W-1:0] v,
                                            input logic [ADDR_W-1:0] idx);
    return v[32'(idx)*REG_W +: REG_W];
  endfunction
  function automatic logic [HI_W-1:0] pick_hi(input logic [NUM_REGS*REG_W-1:0] v,
                                              input logic [ADDR_W-1:0] idx);
    return v[32'(idx)*REG_W + DATA_W +: HI_W];
  endfunction
  function automatic logic [DATA_W-1:0] pick_lo(input logic [NUM_REGS*REG_W-1:0] v,
                                                input logic [ADDR_W-1:0] idx);
    return v[32'(idx)*REG_W +: DATA_W];
  endfunction

  logic is_low, is_void;
  assign is_low  = 32'(addr) < NUM_REGS;
  assign is_void = !is_low && (addr != HI_ADDR);

  // R1: one cycle after a reset cycle, everything reads zero
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert (reg_q == '0 && hi_q == '0 && rd_data == '0);
    end
  end

  a_r2_low_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && is_low) |=> pick(reg_q, $past(addr)) == {$past(hi_q), $past(wr_data)});

  a_r3_hi_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr == HI_ADDR) |=> (hi_q == $past(wr_data[HI_W-1:0])) && $stable(reg_q));

  a_r4_hi_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == HI_ADDR) |=>
      (rd_data[HI_W-1:0] == $past(hi_q)) && (rd_data[DATA_W-1:HI_W] == '0));

  a_r5_low_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && is_low) |=>
      (hi_q == pick_hi($past(reg_q), $past(addr))) && (rd_data == pick_lo($past(reg_q), $past(addr))));

  a_r7_unmapped: assert property (@(posedge clk) disable iff (rst)
    (is_void && (rd_en || wr_en)) |=>
      $stable(hi_q) && $stable(reg_q) && (!$past(rd_en) || rd_data == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r9_buf_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && is_low) |=> $stable(hi_q));
endmodule

bind split_reg_access hbr_access_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .reg_q(reg_q), .hi_q(hi_q)
);

// File: tb/tb_split_reg_access.sv
module tb_split_reg_access;
  localparam int ADDR_W = 4, DATA_W = 8, REG_W = 10, NUM_REGS = 5;
  localparam logic [3:0] HI = 4'h8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [NUM_REGS*REG_W-1:0] reg_q, snap;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  split_reg_access dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .reg_q(reg_q)
  );

  // {is_read, addr, wdata, expected rd_data}
  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'h8, 8'h03, 8'h00},  // stage 3
    {1'b0, 4'h1, 8'h5A, 8'h00},  // R2 reg1 = 35A
    {1'b0, 4'h8, 8'hFD, 8'h00},  // R3 stage 1 (upper bits ignored)
    {1'b0, 4'h2, 8'hC3, 8'h00},  // reg2 = 1C3
    {1'b0, 4'h3, 8'h77, 8'h00},  // R9 reg3 = 177
    {1'b0, 4'h8, 8'h00, 8'h00},  // stage 0
    {1'b0, 4'h4, 8'hFF, 8'h00},  // R6 reg4 = 0FF
    {1'b1, 4'h1, 8'h00, 8'h5A},  // R5
    {1'b1, 4'h8, 8'h00, 8'h03},  // R4
    {1'b1, 4'h4, 8'h00, 8'hFF},
    {1'b1, 4'h8, 8'h00, 8'h00},
    {1'b1, 4'h3, 8'h00, 8'h77},
    {1'b1, 4'h8, 8'h00, 8'h01},
    {1'b1, 4'h2, 8'h00, 8'hC3},
    {1'b1, 4'h8, 8'h00, 8'h01},
    {1'b1, 4'h0, 8'h00, 8'h00},
    {1'b1, 4'h8, 8'h00, 8'h00},
    {1'b0, 4'h8, 8'h02, 8'h00},
    {1'b0, 4'h0, 8'h11, 8'h00},  // reg0 = 211
    {1'b1, 4'h0, 8'h00, 8'h11},
    {1'b1, 4'h8, 8'h00, 8'h02}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [REG_W-1:0] rg(input int i);
    return reg_q[i*REG_W +: REG_W];
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reg_q after reset", 32'(reg_q == '0), 32'd1);
    chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
    do_rd(HI);
    chk("R1 staging after reset", 32'(rd_data), 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20]) begin
        do_rd(VEC[k][19:16]);
        chk($sformatf("R4/R5 vector %0d", k), 32'(rd_data), 32'(VEC[k][7:0]));
      end else begin
        do_wr(VEC[k][19:16], VEC[k][15:8]);
      end
    end

    chk("R2 reg0", 32'(rg(0)), 32'h211);
    chk("R2 reg1", 32'(rg(1)), 32'h35A);
    chk("R9 reg2 shared stage", 32'(rg(2)), 32'h1C3);
    chk("R9 reg3 shared stage", 32'(rg(3)), 32'h177);
    chk("R6 reg4 eight-bit", 32'(rg(4)), 32'h0FF);

    // R3: staging write leaves registers alone
    snap = reg_q;
    do_wr(HI, 8'hFF);
    chk("R3 regs unchanged", 32'(reg_q == snap), 32'd1);
    do_rd(HI);
    chk("R3 staging low bits", 32'(rd_data), 32'h3);

    // R7: unmapped write and read
    do_wr(HI, 8'h01);
    snap = reg_q;
    do_wr(4'hA, 8'h55);
    chk("R7 unmapped write regs", 32'(reg_q == snap), 32'd1);
    do_rd(4'hC);
    chk("R7 unmapped read zero", 32'(rd_data), 32'h0);
    do_rd(HI);
    chk("R7 staging untouched", 32'(rd_data), 32'h1);

    // R8: hold while idle
    do_rd(4'h1);
    repeat (4) @(negedge clk);
    chk("R8 rd_data held", 32'(rd_data), 32'h5A);
    addr = 4'h3;
    @(negedge clk);
    chk("R8 held on addr change", 32'(rd_data), 32'h5A);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-run reg_q", 32'(reg_q == '0), 32'd1);
    chk("R1 mid-run rd_data", 32'(rd_data), 32'h0);
    do_rd(HI);
    chk("R1 mid-run staging", 32'(rd_data), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule